// File: doc/BRIEF.md
# Replaying FIFO with Half-Full Status

This block is a first-in/first-out buffer for 9-bit words. The depth is a parameter and must be a power of two. All activity happens on one clock. The write strobe, the read strobe and the rewind strobe are active-low levels. Each clock edge at which a strobe is sampled low counts as one operation.

The block reports three active-low status flags: one for empty, one for full, and one for more than half full. While the full flag is asserted, writes are refused. While the empty flag is asserted, reads are refused.

A rewind pulse sends the read side back to the first storage location. The write side is not moved. The words stored since reset can then be read out again in their original order.

The read word comes out of a register, one cycle after the read is accepted. It is accompanied by an output-enable that is high only in that cycle. This models a bus that floats between reads. The ninth bit is carried like any other bit and is not interpreted.

Top module: `replay_fifo`

## Requirements
- R1: Asserting `rst_n` low takes effect at once, without waiting for a clock. Both locations return to the first entry, `empty_n` goes low, `full_n` and `half_n` go high, and `dout_oe` goes low. Release from reset is synchronised by two clock edges.
- R2: A write is accepted when `wr_n` is low, `rt_n` is high and `full_n` is high. An accepted write stores `din`. Words are read back in write order, with all 9 bits unchanged.
- R3: A read while `empty_n` is low is ignored. The read location does not move, and `dout_oe` stays low in the following cycle.
- R4: `full_n` goes low when the occupancy reaches DEPTH. A write while `full_n` is low is ignored, so its word is never read back.
- R5: `empty_n` is low exactly when the occupancy is zero.
- R6: `half_n` is low exactly while the occupancy exceeds DEPTH/2. A write from DEPTH/2 sets it low. A read back to DEPTH/2 releases it.
- R7: A cycle with `rt_n` low sets the read location to the first entry and leaves the write location unchanged. The occupancy becomes the number of writes since reset, which is at most DEPTH. All flags follow the new occupancy.
- R8: The environment must keep `wr_n` and `rd_n` high while `rst_n` is low and while `rt_n` is low.
- R9: When a read and a write arrive in the same cycle, both take effect and the occupancy is unchanged. On an empty buffer only the write takes effect. On a full buffer only the read takes effect.
- R10: `dout` carries the read word, and `dout_oe` is high, in the cycle after an accepted read. In every other cycle `dout_oe` is low.
- R11: All flags are registered and change at the same clock edge that performs the operation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low read strobe |
| rt_n | input | 1 | Active-low rewind of the read side |
| din | input | 9 | Write data |
| dout | output | 9 | Registered read data |
| dout_oe | output | 1 | High while `dout` carries a read word |
| empty_n | output | 1 | Low when the buffer is empty |
| full_n | output | 1 | Low when the buffer is full |
| half_n | output | 1 | Low when more than half full |

## Verification
The hardest state to reach is the replay after a partial drain. The read side must already have moved past several entries, and the write side must sit between half and full depth. A rewind at that point must then restore both the old data order and the half-full flag.

The stimulus gets there in stages. It fills the buffer, drains part of it, rewinds, and then keeps writing past the half mark. A second rewind follows. The scoreboard queue is rebuilt from the full write history at each rewind. The same sequence also places simultaneous read and write strobes on an empty buffer and on a full buffer.

// File: rtl/replay_fifo_pkg.sv
package replay_fifo_pkg;
  localparam int unsigned WORD_W = 9;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/replay_fifo_rstsync.sv
module replay_fifo_rstsync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/replay_fifo_mem.sv
module replay_fifo_mem
  import replay_fifo_pkg::*;
#(
  parameter  int unsigned DEPTH = 512,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  word_t         wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output word_t         rdata
);
  word_t store [DEPTH];

  always_ff @(posedge clk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/replay_fifo_ctrl.sv
module replay_fifo_ctrl #(
  parameter  int unsigned DEPTH = 512,
  localparam int unsigned AW    = $clog2(DEPTH),
  localparam int unsigned PW    = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_n,
  input  logic          rd_n,
  input  logic          rt_n,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic          rd_en,
  output logic [AW-1:0] rd_addr,
  output logic          empty_n,
  output logic          full_n,
  output logic          half_n,
  output logic          dout_oe
);
  localparam logic [PW-1:0] FULL_C = PW'(DEPTH);
  localparam logic [PW-1:0] HALF_C = PW'(DEPTH / 2);

  logic [PW-1:0] wr_ptr_q, wr_ptr_d;
  logic [AW-1:0] rd_ptr_q, rd_ptr_d;
  logic [PW-1:0] cnt_q, cnt_d;
  logic [PW-1:0] replay_cnt;
  logic          empty_n_q, full_n_q, half_n_q;
  logic          empty_n_d, full_n_d, half_n_d;
  logic          oe_q;
  logic          wr_ok, rd_ok, upd_en;

  // accept decisions use registered flags
  assign wr_ok  = !wr_n && full_n_q  && rt_n;
  assign rd_ok  = !rd_n && empty_n_q && rt_n;
  assign upd_en = wr_ok || rd_ok || !rt_n;

  // occupancy after rewind: writes since reset, DEPTH when the write side wrapped once
  assign replay_cnt = (wr_ptr_q[AW] && (wr_ptr_q[AW-1:0] == '0))
                      ? FULL_C : {1'b0, wr_ptr_q[AW-1:0]};

  always_comb begin
    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (!rt_n) begin
      rd_ptr_d = '0;
      cnt_d    = replay_cnt;
    end else begin
      if (wr_ok) wr_ptr_d = wr_ptr_q + 1'b1;
      if (rd_ok) rd_ptr_d = rd_ptr_q + 1'b1;
      case ({wr_ok, rd_ok})
        2'b10:   cnt_d = cnt_q + 1'b1;
        2'b01:   cnt_d = cnt_q - 1'b1;
        default: cnt_d = cnt_q;
      endcase
    end
    empty_n_d = (cnt_d != '0);
    full_n_d  = (cnt_d != FULL_C);
    half_n_d  = !(cnt_d > HALF_C);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q  <= '0;
      rd_ptr_q  <= '0;
      cnt_q     <= '0;
      empty_n_q <= 1'b0;
      full_n_q  <= 1'b1;
      half_n_q  <= 1'b1;
    end else if (upd_en) begin
      wr_ptr_q  <= wr_ptr_d;
      rd_ptr_q  <= rd_ptr_d;
      cnt_q     <= cnt_d;
      empty_n_q <= empty_n_d;
      full_n_q  <= full_n_d;
      half_n_q  <= half_n_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) oe_q <= 1'b0;
    else        oe_q <= rd_ok;
  end

  assign wr_en   = wr_ok;
  assign wr_addr = wr_ptr_q[AW-1:0];
  assign rd_en   = rd_ok;
  assign rd_addr = rd_ptr_q;
  assign empty_n = empty_n_q;
  assign full_n  = full_n_q;
  assign half_n  = half_n_q;
  assign dout_oe = oe_q;
endmodule

// File: rtl/replay_fifo.sv
module replay_fifo
  import replay_fifo_pkg::*;
#(
  parameter int unsigned DEPTH = 512
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic              rd_n,
  input  logic              rt_n,
  input  logic [WORD_W-1:0] din,
  output logic [WORD_W-1:0] dout,
  output logic              dout_oe,
  output logic              empty_n,
  output logic              full_n,
  output logic              half_n
);
  localparam int unsigned AW = $clog2(DEPTH);

  logic          rst_n_sync;
  logic          wr_en, rd_en;
  logic [AW-1:0] wr_addr, rd_addr;

  replay_fifo_rstsync #(.STAGES(2)) u_rst (
    .clk       (clk),
    .rst_n_in  (rst_n),
    .rst_n_out (rst_n_sync)
  );

  replay_fifo_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk     (clk),
    .rst_n   (rst_n_sync),
    .wr_n    (wr_n),
    .rd_n    (rd_n),
    .rt_n    (rt_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .rd_en   (rd_en),
    .rd_addr (rd_addr),
    .empty_n (empty_n),
    .full_n  (full_n),
    .half_n  (half_n),
    .dout_oe (dout_oe)
  );

  replay_fifo_mem #(.DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (wr_en),
    .waddr (wr_addr),
    .wdata (din),
    .re    (rd_en),
    .raddr (rd_addr),
    .rdata (dout)
  );
endmodule

// File: rtl/replay_fifo_chk.sv
module replay_fifo_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_n,
  input logic rd_n,
  input logic rt_n,
  input logic dout_oe,
  input logic empty_n,
  input logic full_n,
  input logic half_n
);
  // R8
  reset_idle_chk: assert property (@(posedge clk) !rst_n |-> (wr_n && rd_n));

  // R8
  rewind_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rt_n |-> (wr_n && rd_n));

  // R5
  flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(!empty_n && !full_n));

  // R6
  half_nonempty_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !half_n |-> empty_n);

  // R4
  full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_n && !wr_n && rd_n && rt_n) |=> !full_n);

  // R3
  empty_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!empty_n && !rd_n && wr_n && rt_n) |=> (!empty_n && !dout_oe));

  // R10
  oe_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dout_oe |-> $past(!rd_n && rt_n));
endmodule

bind replay_fifo replay_fifo_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_n    (wr_n),
  .rd_n    (rd_n),
  .rt_n    (rt_n),
  .dout_oe (dout_oe),
  .empty_n (empty_n),
  .full_n  (full_n),
  .half_n  (half_n)
);

// File: tb/replay_fifo_test.sv
module replay_fifo_test;
  localparam int DEPTH = 16;
  localparam int HALF  = DEPTH / 2;

  logic       clk = 1'b0;
  logic       rst_n, wr_n, rd_n, rt_n;
  logic [8:0] din;
  logic [8:0] dout;
  logic       dout_oe, empty_n, full_n, half_n;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  logic [8:0] exp_q[$];
  logic [8:0] hist[$];
  int mcnt = 0;
  bit m_oe = 1'b0;

  always #5 clk = ~clk;

  replay_fifo #(.DEPTH(DEPTH)) uut (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .rd_n(rd_n), .rt_n(rt_n),
    .din(din), .dout(dout), .dout_oe(dout_oe),
    .empty_n(empty_n), .full_n(full_n), .half_n(half_n)
  );

  task automatic check(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic check_flags(input string req);
    check(req, "empty_n", 32'(empty_n), 32'(mcnt != 0));
    check(req, "full_n",  32'(full_n),  32'(mcnt != DEPTH));
    check(req, "half_n",  32'(half_n),  32'(!(mcnt > HALF)));
  endtask

  // driver: one strobe cycle, model updated from pre-edge state
  task automatic step(input bit w, input bit r, input bit t, input logic [8:0] d);
    bit wa, ra;
    @(negedge clk);
    wr_n = !w; rd_n = !r; rt_n = !t; din = d;
    @(posedge clk);
    #1;
    wa = w && !t && (mcnt != DEPTH);
    ra = r && !t && (mcnt != 0);
    if (t) begin
      mcnt  = hist.size();
      exp_q = hist;
    end else begin
      if (wa) begin
        exp_q.push_back(d);
        hist.push_back(d);
      end
      mcnt = mcnt + int'(wa) - int'(ra);
    end
    m_oe = ra;
    wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    mcnt = 0; exp_q.delete(); hist.delete(); m_oe = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
  endtask

  // monitor: scoreboard compare of read words
  always begin
    @(posedge clk);
    #3;
    check("R10", "dout_oe", 32'(dout_oe), 32'(m_oe));
    if (dout_oe && m_oe) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL R2 read word %0h: actual unexpected expected none", dout);
      end else begin
        check("R2", "dout", 32'(dout), 32'(exp_q.pop_front()));
      end
    end
    m_oe = 1'b0;
  end

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; wr_n = 1'b1; rd_n = 1'b1; rt_n = 1'b1; din = '0;
    do_reset();
    // R1 reset state
    check_flags("R1");
    check("R1", "dout_oe", 32'(dout_oe), 32'd0);

    // R3 read on empty
    step(0, 1, 0, '0);
    check_flags("R3");

    // R6 fill to half: flag stays released, R11 flags per edge
    for (int i = 0; i < HALF; i++) begin
      step(1, 0, 0, 9'(9'h100 + i * 3));
      check_flags("R11");
    end
    check("R6", "half_n at half", 32'(half_n), 32'd1);
    step(1, 0, 0, 9'h0A5);
    check("R6", "half_n above half", 32'(half_n), 32'd0);
    step(0, 1, 0, '0);
    check("R6", "half_n back to half", 32'(half_n), 32'd1);

    // R4 fill to full
    while (mcnt < DEPTH) step(1, 0, 0, 9'(9'h1C0 ^ mcnt));
    check_flags("R4");
    check("R4", "full_n low", 32'(full_n), 32'd0);
    step(1, 0, 0, 9'h1FF);
    check_flags("R4");

    // R9 read+write on full: only read
    step(1, 1, 0, 9'h0EE);
    check_flags("R9");
    check("R9", "full_n after rw on full", 32'(full_n), 32'd1);

    // drain
    while (mcnt > 0) step(0, 1, 0, '0);
    check_flags("R5");
    check("R5", "empty_n low", 32'(empty_n), 32'd0);

    // R9 read+write on empty: only write
    step(1, 1, 0, 9'h133);
    check_flags("R9");
    step(1, 1, 0, 9'h044);
    check_flags("R9");
    step(0, 1, 0, '0);
    check_flags("R5");

    // R7 rewind after partial drain
    do_reset();
    for (int i = 0; i < 5; i++) step(1, 0, 0, 9'(9'h1F0 + i));
    for (int i = 0; i < 3; i++) step(0, 1, 0, '0);
    step(0, 0, 1, '0);
    check_flags("R7");
    check("R7", "occupancy after rewind", 32'(empty_n && full_n), 32'd1);
    for (int i = 0; i < 6; i++) step(1, 0, 0, 9'(9'h020 + i));
    check_flags("R7");
    for (int i = 0; i < 4; i++) step(0, 1, 0, '0);
    step(0, 0, 1, '0);
    check_flags("R7");
    check("R7", "half_n after second rewind", 32'(half_n), 32'd0);
    while (mcnt > 0) step(0, 1, 0, '0);
    check_flags("R7");

    // R1 asynchronous reset mid-operation
    for (int i = 0; i < 10; i++) step(1, 0, 0, 9'(i));
    @(negedge clk);
    rst_n = 1'b0;
    mcnt = 0; exp_q.delete(); hist.delete();
    #1;
    check_flags("R1");
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(posedge clk);
    #1;
    check_flags("R1");

    repeat (3) @(posedge clk);
    #4;
    done = 1'b1;
    summary();
    $finish;
  end
endmodule